// File: doc/BRIEF.md
# Aligned quadword load/store sequencer

This block carries out one 128-bit register load or store over a 64-bit memory port. A start strobe hands it a base address, a signed displacement, a register index, the 128-bit source value (used by stores), and a load/store select. The block adds the sign-extended displacement to the base and clears the low four bits of the sum. No alignment fault is raised. It then issues two doubleword memory beats in a fixed order: first the aligned address, then the aligned address plus 8.

A store sends the low half of the source on the first beat and the high half on the second. A load collects the two returned doublewords. Once both have arrived, it presents a single 128-bit register write, with the first beat in the low half. A load that targets register 0 touches no memory and finishes at once. A store from register 0 still writes memory, and the data it writes is zero.

The memory request channel is valid/ready. The block raises `mem_req_valid_o` and holds address, write flag and data unchanged until `mem_req_ready_i` is seen high at a clock edge. Only then may it move to the next beat. For a load, each beat then waits for a one-cycle `mem_rsp_valid_i` pulse that carries the read data. The response channel has no back-pressure, and the memory must not send a response unless a load beat is outstanding. Control (start, busy, done) uses plain level pins.

Top module: `qword_ldst_seq`

## Requirements
- R1: The memory address of every beat is derived from base plus the displacement sign-extended from bit 15, with bits [3:0] of the sum forced to zero. No alignment fault exists.
- R2: The first beat uses the aligned address and, for a store, carries source bits [63:0]. The second beat uses the aligned address plus 8 and carries source bits [127:64].
- R3: While `mem_req_valid_o` is high and `mem_req_ready_i` is low at a clock edge, the next cycle keeps the request valid with unchanged address, write flag and write data.
- R4: A load to a nonzero index raises `rf_we_o` for exactly one cycle, together with `done_o`, only after both read responses have arrived. `rf_wdata_o` is {second-beat data, first-beat data}, and `rf_idx_o` is the target index.
- R5: A load to index 0 issues no memory request and no register write. It raises `done_o` in the cycle after the start strobe.
- R6: A store from index 0 issues both write beats, with all-zero data regardless of `store_data_i`.
- R7: `busy_o` is high from the cycle after an accepted start until the transfer completes. A start strobe while `busy_o` is high is ignored and produces no memory traffic.
- R8: `done_o` pulses for one cycle in the cycle after the completing edge: the second write handshake for a store, or the second read response for a load. `busy_o` is low during that cycle, and a new start may be accepted in it.
- R9: After reset, `busy_o`, `done_o`, `mem_req_valid_o` and `rf_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| is_store_i | input | 1 | 1 = store, 0 = load |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed displacement |
| reg_idx_i | input | 5 | Target (load) or source (store) register index |
| store_data_i | input | 128 | Source register value for stores |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request at this edge |
| mem_req_we_o | output | 1 | Request is a write |
| mem_req_addr_o | output | 32 | Doubleword byte address |
| mem_req_wdata_o | output | 64 | Write data |
| mem_rsp_valid_i | input | 1 | Read data valid pulse |
| mem_rsp_data_i | input | 64 | Read data |
| rf_we_o | output | 1 | Register write strobe |
| rf_idx_o | output | 5 | Register write index |
| rf_wdata_o | output | 128 | Register write value |

## Verification
The hardest case to reach is a start strobe that lands while a transfer is stalled mid-way. This needs the request channel held off or a read response delayed at the same moment the strobe arrives. The bench models memory with random ready stalls and random response latency. It deliberately pulses start, with different operands, in a cycle where busy is high. A scoreboard of expected memory beats then shows that the strobe added no traffic. Misaligned bases with negative displacements, and both register-0 cases, are mixed into a random stream of loads and stores.

// File: rtl/qls_pkg.sv
package qls_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQ_LO  = 3'd1,
    ST_WAIT_LO = 3'd2,
    ST_REQ_HI  = 3'd3,
    ST_WAIT_HI = 3'd4
  } qls_state_e;
endpackage

// File: rtl/qls_addr_gen.sv
module qls_addr_gen #(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 16,
  parameter int ALIGN_LG = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic [ADDR_W-1:0] aligned_o
);
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] eff_addr;

  generate
    if (ADDR_W > OFF_W) begin : g_sext
      assign disp_ext = {{(ADDR_W-OFF_W){offset_i[OFF_W-1]}}, offset_i};
    end else begin : g_trunc
      assign disp_ext = offset_i[ADDR_W-1:0];
    end
  endgenerate

  assign eff_addr  = base_i + disp_ext;
  assign aligned_o = {eff_addr[ADDR_W-1:ALIGN_LG], {ALIGN_LG{1'b0}}};
endmodule

// File: rtl/qls_beat_ctrl.sv
module qls_beat_ctrl
  import qls_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  input  logic skip_i,
  input  logic store_i,
  input  logic req_ready_i,
  input  logic rsp_valid_i,
  output logic idle_o,
  output logic req_valid_o,
  output logic beat_hi_o,
  output logic cap_lo_o,
  output logic cap_hi_o,
  output logic done_o
);
  qls_state_e state_q, state_d;
  logic       finish;
  logic       done_q;

  always_comb begin
    state_d  = state_q;
    finish   = 1'b0;
    cap_lo_o = 1'b0;
    cap_hi_o = 1'b0;
    unique case (state_q)
      ST_IDLE:    if (launch_i && !skip_i) state_d = ST_REQ_LO;
      ST_REQ_LO:  if (req_ready_i) state_d = store_i ? ST_REQ_HI : ST_WAIT_LO;
      ST_WAIT_LO: if (rsp_valid_i) begin
                    state_d  = ST_REQ_HI;
                    cap_lo_o = 1'b1;
                  end
      ST_REQ_HI:  if (req_ready_i) begin
                    if (store_i) begin
                      state_d = ST_IDLE;
                      finish  = 1'b1;
                    end else begin
                      state_d = ST_WAIT_HI;
                    end
                  end
      ST_WAIT_HI: if (rsp_valid_i) begin
                    state_d  = ST_IDLE;
                    finish   = 1'b1;
                    cap_hi_o = 1'b1;
                  end
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish | (launch_i && skip_i && state_q == ST_IDLE);
    end
  end

  assign idle_o      = (state_q == ST_IDLE);
  assign req_valid_o = (state_q == ST_REQ_LO) || (state_q == ST_REQ_HI);
  assign beat_hi_o   = (state_q == ST_REQ_HI) || (state_q == ST_WAIT_HI);
  assign done_o      = done_q;

  // R3
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(beat_hi_o)));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> idle_o);
endmodule

// File: rtl/qls_load_assemble.sv
module qls_load_assemble #(
  parameter int BEAT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_lo_i,
  input  logic              cap_hi_i,
  input  logic [BEAT_W-1:0] rsp_data_i,
  output logic [2*BEAT_W-1:0] qword_o
);
  logic [BEAT_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (cap_lo_i) lo_q <= rsp_data_i;
      if (cap_hi_i) hi_q <= rsp_data_i;
    end
  end

  assign qword_o = {hi_q, lo_q};

  // R4
  one_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_lo_i && cap_hi_i));
endmodule

// File: rtl/qword_ldst_seq.sv
module qword_ldst_seq #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int IDX_W  = 5,
  parameter int BEAT_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                is_store_i,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [OFF_W-1:0]    offset_i,
  input  logic [IDX_W-1:0]    reg_idx_i,
  input  logic [2*BEAT_W-1:0] store_data_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                mem_req_valid_o,
  input  logic                mem_req_ready_i,
  output logic                mem_req_we_o,
  output logic [ADDR_W-1:0]   mem_req_addr_o,
  output logic [BEAT_W-1:0]   mem_req_wdata_o,
  input  logic                mem_rsp_valid_i,
  input  logic [BEAT_W-1:0]   mem_rsp_data_i,
  output logic                rf_we_o,
  output logic [IDX_W-1:0]    rf_idx_o,
  output logic [2*BEAT_W-1:0] rf_wdata_o
);
  localparam int QW_W     = 2 * BEAT_W;
  localparam int BEAT_B   = BEAT_W / 8;
  localparam int ALIGN_LG = $clog2(2 * BEAT_B);
  localparam logic [ADDR_W-1:0] HI_OFS = ADDR_W'(BEAT_B);

  logic              idle, launch, skip;
  logic              beat_hi, cap_lo, cap_hi;
  logic [ADDR_W-1:0] aligned_now;
  logic [ADDR_W-1:0] aligned_q;
  logic              store_q;
  logic [IDX_W-1:0]  idx_q;
  logic [QW_W-1:0]   wdata_q;

  qls_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ALIGN_LG(ALIGN_LG)) addr_i (
    .base_i(base_i), .offset_i(offset_i), .aligned_o(aligned_now));

  assign launch = start_i && idle;
  assign skip   = !is_store_i && (reg_idx_i == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aligned_q <= '0;
      store_q   <= 1'b0;
      idx_q     <= '0;
      wdata_q   <= '0;
    end else if (launch) begin
      aligned_q <= aligned_now;
      store_q   <= is_store_i;
      idx_q     <= reg_idx_i;
      wdata_q   <= (reg_idx_i == '0) ? '0 : store_data_i;
    end
  end

  qls_beat_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .launch_i(launch), .skip_i(skip),
    .store_i(store_q), .req_ready_i(mem_req_ready_i),
    .rsp_valid_i(mem_rsp_valid_i), .idle_o(idle),
    .req_valid_o(mem_req_valid_o), .beat_hi_o(beat_hi),
    .cap_lo_o(cap_lo), .cap_hi_o(cap_hi), .done_o(done_o));

  qls_load_assemble #(.BEAT_W(BEAT_W)) asm_i (
    .clk(clk), .rst_n(rst_n), .cap_lo_i(cap_lo), .cap_hi_i(cap_hi),
    .rsp_data_i(mem_rsp_data_i), .qword_o(rf_wdata_o));

  assign busy_o          = !idle;
  assign mem_req_we_o    = store_q;
  assign mem_req_addr_o  = beat_hi ? (aligned_q | HI_OFS) : aligned_q;
  assign mem_req_wdata_o = beat_hi ? wdata_q[QW_W-1:BEAT_W] : wdata_q[BEAT_W-1:0];
  assign rf_we_o         = done_o && !store_q && (idx_q != '0);
  assign rf_idx_o        = idx_q;

  // R1
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> (mem_req_addr_o[ALIGN_LG-2:0] == '0));

  // R3
  req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      ($stable(mem_req_addr_o) && $stable(mem_req_wdata_o) && $stable(mem_req_we_o)));

  // R4
  rf_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (done_o && !busy_o));

  // R5
  skip_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !is_store_i && reg_idx_i == '0) |=>
      (done_o && !mem_req_valid_o && !rf_we_o));

  // R6
  zero_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && mem_req_we_o && idx_q == '0) |-> (mem_req_wdata_o == '0));

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> (busy_o || done_o));
endmodule

// File: tb/qword_ldst_seq_tb_top.sv
module qword_ldst_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic         start_i = 0, is_store_i = 0;
  logic [31:0]  base_i = 0;
  logic [15:0]  offset_i = 0;
  logic [4:0]   reg_idx_i = 0;
  logic [127:0] store_data_i = 0;
  logic         busy_o, done_o, mem_req_valid_o, mem_req_we_o;
  logic         mem_req_ready_i = 0, mem_rsp_valid_i = 0;
  logic [31:0]  mem_req_addr_o;
  logic [63:0]  mem_req_wdata_o, mem_rsp_data_i = 0;
  logic         rf_we_o;
  logic [4:0]   rf_idx_o;
  logic [127:0] rf_wdata_o;

  qword_ldst_seq dut_i (.*);

  typedef struct { logic we; logic [31:0] addr; logic [63:0] data; } beat_t;
  typedef struct { logic we; logic [4:0] idx; logic [127:0] data; } fin_t;
  beat_t beat_q[$];
  fin_t  fin_q[$];

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic        rsp_pend = 0;
  int          rsp_dly = 0;
  logic [31:0] rsp_addr = 0;

  function automatic logic [63:0] mem_fn(input logic [31:0] a);
    return {a, a ^ 32'hA5A5_5A5A};
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model and monitor
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      mem_rsp_valid_i = 1'b0;
      if (rsp_pend) begin
        if (rsp_dly == 0) begin
          mem_rsp_valid_i = 1'b1;
          mem_rsp_data_i  = mem_fn(rsp_addr);
          rsp_pend = 1'b0;
        end else rsp_dly--;
      end
      if (done_o) begin
        fin_t f;
        if (fin_q.size() == 0) check(0, "R8 unexpected done", 1, 0);
        else begin
          f = fin_q.pop_front();
          check(rf_we_o == f.we, "R4/R5 rf_we", rf_we_o, f.we);
          if (f.we) begin
            check(rf_idx_o == f.idx, "R4 rf_idx", rf_idx_o, f.idx);
            check(rf_wdata_o == f.data, "R4 rf_wdata", rf_wdata_o, f.data);
          end
          check(!busy_o, "R8 busy low with done", busy_o, 0);
        end
      end else check(!rf_we_o, "R4 rf_we without done", rf_we_o, 0);
      mem_req_ready_i = ($urandom % 10) < 6;
      if (mem_req_valid_o && mem_req_ready_i) begin
        beat_t b;
        if (beat_q.size() == 0) check(0, "R5/R7 unexpected request", mem_req_addr_o, 0);
        else begin
          b = beat_q.pop_front();
          check(mem_req_addr_o == b.addr, "R1/R2 beat address", mem_req_addr_o, b.addr);
          check(mem_req_we_o == b.we, "R2 beat direction", mem_req_we_o, b.we);
          if (b.we) check(mem_req_wdata_o == b.data, "R2/R6 beat data", mem_req_wdata_o, b.data);
          if (!mem_req_we_o) begin
            rsp_pend = 1'b1;
            rsp_dly  = $urandom % 3;
            rsp_addr = mem_req_addr_o;
          end
        end
      end
    end
  end

  task automatic run_op(input bit st, input logic [31:0] base, input logic [15:0] off,
                        input logic [4:0] idx, input logic [127:0] data, input bit poke);
    logic [31:0]  al;
    logic [127:0] sdat;
    al   = (base + {{16{off[15]}}, off}) & ~32'hF;
    sdat = (idx == 0) ? 128'h0 : data;
    while (busy_o) @(negedge clk);
    start_i = 1; is_store_i = st; base_i = base; offset_i = off;
    reg_idx_i = idx; store_data_i = data;
    if (st) begin
      beat_q.push_back('{1'b1, al, sdat[63:0]});
      beat_q.push_back('{1'b1, al + 32'd8, sdat[127:64]});
      fin_q.push_back('{1'b0, idx, 128'h0});
    end else if (idx == 0) begin
      fin_q.push_back('{1'b0, idx, 128'h0});
    end else begin
      beat_q.push_back('{1'b0, al, 64'h0});
      beat_q.push_back('{1'b0, al + 32'd8, 64'h0});
      fin_q.push_back('{1'b1, idx, {mem_fn(al + 32'd8), mem_fn(al)}});
    end
    @(negedge clk);
    start_i = 0;
    if (poke && busy_o) begin
      // R7: this strobe must be ignored
      start_i = 1; is_store_i = 1; base_i = 32'hDEAD_0000; reg_idx_i = 5'd9;
      store_data_i = {4{32'hBAD0_BAD0}};
      check(busy_o, "R7 busy during transfer", busy_o, 1);
      @(negedge clk);
      start_i = 0;
    end
    while (fin_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy_o && !done_o && !mem_req_valid_o && !rf_we_o, "R9 reset state",
          {busy_o, done_o, mem_req_valid_o, rf_we_o}, 0);
    run_op(1, 32'h0000_1000, 16'h0025, 5'd3, {64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888}, 0); // R1 R2
    run_op(0, 32'h2000_0008, 16'hFFFD, 5'd7, 0, 0);  // R1 negative offset, R4
    run_op(0, 32'h0000_4000, 16'h0010, 5'd0, 0, 0);  // R5
    check(beat_q.size() == 0, "R5 no traffic", beat_q.size(), 0);
    run_op(1, 32'h0000_5003, 16'h0001, 5'd0, {128{1'b1}}, 0); // R6
    run_op(0, 32'h0000_6000, 16'h7FFF, 5'd12, 0, 1); // R7 ignored start
    run_op(1, 32'h0000_7000, 16'h8000, 5'd31, {2{64'hCAFE_F00D_0123_4567}}, 1); // R7, R3
    for (int i = 0; i < 40; i++) begin
      logic [4:0] ix;
      ix = (i % 7 == 0) ? 5'd0 : 5'($urandom);
      run_op(1'($urandom), $urandom, 16'($urandom), ix,
             {$urandom, $urandom, $urandom, $urandom}, 1'($urandom));
    end
    repeat (5) @(negedge clk);
    check(beat_q.size() == 0 && fin_q.size() == 0, "R8 all completions seen",
          beat_q.size() + fin_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 50000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule